// File: doc/BRIEF.md
# Protection lookaside address checker

This block decides whether a single memory access may proceed. Each access carries an address, a write flag, an instruction-fetch flag, a size code, a supervisor flag and a flag for the second address generator. The block compares it against a bank of programmable protection descriptors. Each descriptor is a base address plus an attribute word. A fixed set of implicit rules covers the on-chip L1 window and the memory-mapped register (MMR) window.

One clock after a request, the block raises a done strobe with a 3-bit result code. The possible results are ok, miss, protection violation, multiple hit, misaligned and external-address error. When the access faults, the block loads a fault status word and a fault address into either the data-side or the instruction-side fault registers. A single write port programs the descriptor bases, the descriptor attributes and the control word.

Top module: `prot_lookaside_chk`

## Requirements
- R1: After reset, `res_done` is 0, `res_code` is 0, all four fault registers are 0, every descriptor is invalid, and checking is enabled (control bit 0 = 1).
- R2: When the address is not a multiple of 2^`req_szlog` bytes, the result is code 4 (misaligned). This outranks every other outcome.
- R3: A descriptor takes part only when attribute bit 0 (valid) is set. Attribute bits 17:16 select its span: 0 = 1 KB, 1 = 4 KB, 2 = 1 MB, 3 = 4 MB. It matches when base <= addr < base + span.
- R4: With checking enabled, an access that matches no descriptor and falls under no implicit rule returns code 1 (miss).
- R5: Two or more matching descriptors return code 3 (multiple hit). The status mask then carries every matching entry.
- R6: A single-hit write returns code 2 (violation) in any of these cases: user mode without attribute bit 2 (user write); supervisor mode without bit 3 (supervisor write); or bit 6 (L1 cacheable) set while bit 5 (write-through) and bit 4 (dirty) are both clear.
- R7: A single-hit read faults (code 2) only in user mode without attribute bit 1 (user read). Supervisor reads never fault on a descriptor.
- R8: With control bit 0 clear, the access counts as exactly one hit, so descriptors are ignored and only the implicit rules apply.
- R9: For addresses >= `MMR_BASE`, an instruction fetch returns miss. A data access returns violation in user mode or when `req_dag1` is set. A supervisor data access is ok.
- R10: Inside the L1 window (top byte 0xFF, below the MMR window), an instruction fetch is ok only where addr[31:20] = 0xFFA, and violation elsewhere. A data access is ok except where addr[31:20] = 0xFFA. There it returns code 5 (external-address error) and leaves all fault registers unchanged.
- R11: On a fault (codes 1 to 4), the status word for the access side becomes {12'b0, miss, dag1, supervisor, write, 16-bit match mask}, and the fault address for that side becomes the access address.
- R12: A data-side fault also loads the instruction-side fault address with `req_pc` and the instruction-side status with the supervisor flag at bit 17 only.
- R13: `res_done` is high exactly in the cycle after a cycle with `req_valid` high. Code 0 results leave the fault registers unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | 0 = descriptor base, 1 = descriptor attribute, 2 = control word |
| cfg_idx | input | 4 | Descriptor index |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | Access to check this cycle |
| req_addr | input | 32 | Access address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_inst | input | 1 | 1 = instruction fetch, 0 = data access |
| req_szlog | input | 2 | Access size is 2^szlog bytes |
| req_supv | input | 1 | Supervisor mode |
| req_dag1 | input | 1 | Access issued by the second address generator |
| req_pc | input | 32 | Program counter of the access |
| res_done | output | 1 | Result valid strobe |
| res_code | output | 3 | 0 ok, 1 miss, 2 violation, 3 multiple hit, 4 misaligned, 5 external-address error |
| dflt_status | output | 32 | Data-side fault status |
| dflt_addr | output | 32 | Data-side fault address |
| iflt_status | output | 32 | Instruction-side fault status |
| iflt_addr | output | 32 | Instruction-side fault address |

## Verification
The bench checks the exclusive upper bound of each of the four page spans. A design that compared with <= would report ok one byte past the end, where miss is expected. It also places a misaligned address inside an overlapping pair of descriptors; a wrong priority would report multiple hit there. A clean write-back page is written by a supervisor that holds write permission, which catches a design that checks only the permission bits. The bench probes the L1 data window to confirm that the external-address error leaves the fault registers untouched. It then turns checking off and confirms that the implicit MMR rules still apply.

// File: rtl/prot_lookaside_chk.sv
module prot_lookaside_chk #(
  parameter int          NENT     = 16,
  parameter logic [31:0] MMR_BASE = 32'hFFC0_0000
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_kind,
  input  logic [$clog2(NENT)-1:0] cfg_idx,
  input  logic [31:0]             cfg_wdata,
  input  logic                    req_valid,
  input  logic [31:0]             req_addr,
  input  logic                    req_write,
  input  logic                    req_inst,
  input  logic [1:0]              req_szlog,
  input  logic                    req_supv,
  input  logic                    req_dag1,
  input  logic [31:0]             req_pc,
  output logic                    res_done,
  output logic [2:0]              res_code,
  output logic [31:0]             dflt_status,
  output logic [31:0]             dflt_addr,
  output logic [31:0]             iflt_status,
  output logic [31:0]             iflt_addr
);
  localparam int B_VALID = 0, B_URD = 1, B_UWR = 2, B_SWR = 3;
  localparam int B_DIRTY = 4, B_WTHRU = 5, B_L1C = 6;
  localparam logic [2:0] C_OK = 3'd0, C_MISS = 3'd1, C_VIOL = 3'd2;
  localparam logic [2:0] C_MULTI = 3'd3, C_MAL = 3'd4, C_HWERR = 3'd5;

  typedef enum logic [2:0] {IM_VALID, IM_NONE, IM_MISS, IM_VIOL, IM_HWERR} imp_e;

  logic [31:0] base_q [NENT];
  logic [31:0] attr_q [NENT];
  logic        en_q;

  logic [NENT-1:0] hit, deny;

  for (genvar i = 0; i < NENT; i++) begin : g_ent
    logic [32:0] span, lim;
    logic [31:0] at;
    assign at = attr_q[i];
    always_comb begin
      case (at[17:16])
        2'd0:    span = 33'h0_0000_0400;
        2'd1:    span = 33'h0_0000_1000;
        2'd2:    span = 33'h0_0010_0000;
        default: span = 33'h0_0040_0000;
      endcase
    end
    assign lim    = {1'b0, base_q[i]} + span;
    assign hit[i] = at[B_VALID] && (req_addr >= base_q[i]) && ({1'b0, req_addr} < lim);
    assign deny[i] = req_write
      ? ((!req_supv && !at[B_UWR]) || (req_supv && !at[B_SWR]) ||
         (at[B_L1C] && !at[B_WTHRU] && !at[B_DIRTY]))
      : (!req_supv && !at[B_URD]);
  end

  logic [3:0]  szm;
  logic        misal, multi, one, deny_any, in_l1, l1_win;
  logic [NENT-1:0] mask;
  imp_e        imp;
  logic [2:0]  code;

  assign szm      = (4'd1 << req_szlog) - 4'd1;
  assign misal    = |(req_addr[3:0] & szm);
  assign multi    = $countones(hit) > 1;
  assign one      = en_q ? ($countones(hit) == 1) : 1'b1;
  assign deny_any = en_q && |(hit & deny);
  assign mask     = en_q ? hit : '0;
  assign in_l1    = req_addr[31:24] == 8'hFF;
  assign l1_win   = req_addr[31:20] == 12'hFFA;

  always_comb begin
    if (req_addr >= MMR_BASE)
      imp = req_inst ? IM_MISS : ((!req_supv || req_dag1) ? IM_VIOL : IM_VALID);
    else if (in_l1)
      imp = req_inst ? (l1_win ? IM_VALID : IM_VIOL) : (l1_win ? IM_HWERR : IM_VALID);
    else
      imp = IM_NONE;

    if (misal)                code = C_MAL;
    else if (en_q && multi)   code = C_MULTI;
    else if (deny_any)        code = C_VIOL;
    else begin
      case (imp)
        IM_VALID: code = C_OK;
        IM_NONE:  code = one ? C_OK : C_MISS;
        IM_MISS:  code = C_MISS;
        IM_VIOL:  code = C_VIOL;
        default:  code = C_HWERR;
      endcase
    end
  end

  logic        log_en;
  logic [31:0] st_word;
  assign log_en  = req_valid && (code != C_OK) && (code != C_HWERR);
  assign st_word = {12'd0, code == C_MISS, req_dag1, req_supv, req_write, 16'(mask)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_done    <= 1'b0;
      res_code    <= C_OK;
      dflt_status <= '0;
      dflt_addr   <= '0;
      iflt_status <= '0;
      iflt_addr   <= '0;
      en_q        <= 1'b1;
      for (int i = 0; i < NENT; i++) begin
        base_q[i] <= '0;
        attr_q[i] <= '0;
      end
    end else begin
      res_done <= req_valid;
      if (req_valid) res_code <= code;
      if (cfg_we) begin
        case (cfg_kind)
          2'd0:    base_q[cfg_idx] <= cfg_wdata;
          2'd1:    attr_q[cfg_idx] <= cfg_wdata;
          2'd2:    en_q            <= cfg_wdata[0];
          default: ;
        endcase
      end
      if (log_en) begin
        if (req_inst) begin
          iflt_status <= st_word;
          iflt_addr   <= req_addr;
        end else begin
          dflt_status <= st_word;
          dflt_addr   <= req_addr;
          iflt_status <= {14'd0, req_supv, 17'd0};
          iflt_addr   <= req_pc;
        end
      end
    end
  end
endmodule

// File: rtl/prot_lookaside_chk_sva.sv
module prot_lookaside_chk_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_inst,
  input logic [1:0]  req_szlog,
  input logic [31:0] req_pc,
  input logic        res_done,
  input logic [2:0]  res_code,
  input logic [31:0] dflt_status,
  input logic [31:0] dflt_addr,
  input logic [31:0] iflt_status,
  input logic [31:0] iflt_addr
);
  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_done); // R13
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_done); // R13
  AST_ODD_ADDR_MISALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[0] && req_szlog != 2'd0) |=> res_code == 3'd4); // R2
  AST_OK_KEEPS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_code == 3'd0) |-> ($stable(dflt_status) && $stable(iflt_status)
      && $stable(dflt_addr) && $stable(iflt_addr))); // R13
  AST_HWERR_KEEPS_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_code == 3'd5) |-> ($stable(dflt_addr) && $stable(iflt_addr))); // R10
  AST_DATA_MISS_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_code == 3'd1 && !$past(req_inst)) |->
      (dflt_status[19] && dflt_addr == $past(req_addr))); // R11
  AST_DATA_FAULT_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_code >= 3'd1 && res_code <= 3'd4 && !$past(req_inst)) |->
      (iflt_addr == $past(req_pc))); // R12
endmodule

bind prot_lookaside_chk prot_lookaside_chk_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .req_inst(req_inst), .req_szlog(req_szlog), .req_pc(req_pc),
  .res_done(res_done), .res_code(res_code), .dflt_status(dflt_status),
  .dflt_addr(dflt_addr), .iflt_status(iflt_status), .iflt_addr(iflt_addr)
);

// File: tb/sim_prot_lookaside_chk.sv
module sim_prot_lookaside_chk;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_kind = '0;
  logic [3:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_inst = 1'b0;
  logic        req_supv = 1'b0, req_dag1 = 1'b0;
  logic [31:0] req_addr = '0, req_pc = 32'h0000_8000;
  logic [1:0]  req_szlog = 2'd2;
  logic        res_done;
  logic [2:0]  res_code;
  logic [31:0] dflt_status, dflt_addr, iflt_status, iflt_addr;

  int checks = 0, fails = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  prot_lookaside_chk u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model
  logic [31:0] m_base [16];
  logic [31:0] m_attr [16];
  bit          m_en;
  bit          e_done;
  logic [2:0]  e_code;
  logic [31:0] e_dst, e_dad, e_ist, e_iad;

  always @(posedge clk) begin
    int nh, imp, c, sh;
    bit bad;
    logic [15:0] mk;
    longint lo, hi;
    if (!rst_n) begin
      m_en = 1; e_done = 0; e_code = 0; e_dst = 0; e_dad = 0; e_ist = 0; e_iad = 0;
      for (int i = 0; i < 16; i++) begin m_base[i] = 0; m_attr[i] = 0; end
    end else begin
      if (req_valid) begin
        nh = 0; mk = 0; bad = 0;
        if (m_en) begin
          for (int i = 0; i < 16; i++) begin
            if (m_attr[i][0]) begin
              sh = (m_attr[i][17:16] == 0) ? 10 : (m_attr[i][17:16] == 1) ? 12 :
                   (m_attr[i][17:16] == 2) ? 20 : 22;
              lo = longint'(m_base[i]);
              hi = lo + (longint'(1) << sh);
              if (longint'(req_addr) >= lo && longint'(req_addr) < hi) begin
                nh++; mk[i] = 1'b1;
                if (req_write) begin
                  if (!req_supv && !m_attr[i][2]) bad = 1;
                  if (req_supv && !m_attr[i][3]) bad = 1;
                  if (m_attr[i][6] && !m_attr[i][5] && !m_attr[i][4]) bad = 1;
                end else if (!req_supv && !m_attr[i][1]) bad = 1;
              end
            end
          end
        end else nh = 1;
        // implicit: 0 valid, 1 none, 2 miss, 3 viol, 4 hwerr
        if (req_addr >= 32'hFFC0_0000) imp = req_inst ? 2 : ((!req_supv || req_dag1) ? 3 : 0);
        else if (req_addr[31:24] == 8'hFF) begin
          if (req_inst) imp = (req_addr[31:20] == 12'hFFA) ? 0 : 3;
          else          imp = (req_addr[31:20] == 12'hFFA) ? 4 : 0;
        end else imp = 1;
        if ((req_addr % (32'd1 << req_szlog)) != 0) c = 4;
        else if (nh >= 2) c = 3;
        else if (bad) c = 2;
        else if (imp == 0) c = 0;
        else if (imp == 1) c = (nh == 1) ? 0 : 1;
        else if (imp == 2) c = 1;
        else if (imp == 3) c = 2;
        else c = 5;
        e_code = 3'(c);
        if (c >= 1 && c <= 4) begin
          if (req_inst) begin
            e_ist = {12'd0, c == 1, req_dag1, req_supv, req_write, mk};
            e_iad = req_addr;
          end else begin
            e_dst = {12'd0, c == 1, req_dag1, req_supv, req_write, mk};
            e_dad = req_addr;
            e_ist = req_supv ? 32'h0002_0000 : 32'h0;
            e_iad = req_pc;
          end
        end
      end
      e_done = req_valid;
      if (cfg_we) begin
        if (cfg_kind == 0) m_base[cfg_idx] = cfg_wdata;
        else if (cfg_kind == 1) m_attr[cfg_idx] = cfg_wdata;
        else if (cfg_kind == 2) m_en = cfg_wdata[0];
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(res_done === e_done, "R13 done vs model", 32'(res_done), 32'(e_done));
      chk(res_code === e_code, "R13 code vs model", 32'(res_code), 32'(e_code));
      chk(dflt_status === e_dst && dflt_addr === e_dad, "R11 data fault regs vs model", dflt_status, e_dst);
      chk(iflt_status === e_ist && iflt_addr === e_iad, "R12 inst fault regs vs model", iflt_status, e_ist);
    end
  end

  task automatic cfg(input logic [1:0] k, input logic [3:0] idx, input logic [31:0] d);
    cfg_we = 1; cfg_kind = k; cfg_idx = idx; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic acc(input logic [31:0] a, input bit wr, input bit inst, input logic [1:0] sz,
                     input bit sv, input bit dg, input logic [2:0] exp, input string tag);
    req_valid = 1; req_addr = a; req_write = wr; req_inst = inst; req_szlog = sz;
    req_supv = sv; req_dag1 = dg; req_pc = req_pc + 32'd4;
    @(negedge clk);
    req_valid = 0;
    chk(res_done === 1'b1 && res_code === exp, tag, 32'(res_code), 32'(exp));
  endtask

  initial begin
    logic [31:0] keep_d, keep_i;
    repeat (3) @(negedge clk);
    chk(res_done === 0 && res_code === 0 && dflt_status === 0 && dflt_addr === 0 &&
        iflt_status === 0 && iflt_addr === 0, "R1 reset state", dflt_status, 0);
    rst_n = 1;
    @(negedge clk);
    acc(32'h0000_2000, 0, 0, 2, 0, 0, 3'd1, "R1 no valid descriptors after reset -> miss");

    cfg(0, 0, 32'h0000_1000); cfg(1, 0, 32'h0001_001F);
    acc(32'h0000_1004, 0, 0, 2, 0, 0, 3'd0, "R3 4K page hit");
    acc(32'h0000_1FFC, 0, 0, 2, 0, 0, 3'd0, "R3 last word of 4K page");
    acc(32'h0000_2000, 0, 0, 2, 0, 0, 3'd1, "R4 one past 4K page -> miss");
    chk(dflt_status === 32'h0008_0000 && dflt_addr === 32'h0000_2000, "R11 miss status", dflt_status, 32'h0008_0000);
    chk(iflt_status === 32'h0 && iflt_addr === req_pc, "R12 user data fault pc", iflt_addr, req_pc);
    acc(32'h0000_1002, 0, 0, 2, 0, 0, 3'd4, "R2 misaligned word");
    acc(32'h0000_1003, 0, 0, 0, 0, 0, 3'd0, "R2 byte never misaligned");

    cfg(0, 1, 32'h0000_1000); cfg(1, 1, 32'h0000_0003);
    acc(32'h0000_1100, 0, 0, 2, 1, 0, 3'd3, "R5 overlapping entries -> multi");
    chk(dflt_status === 32'h0002_0003, "R5 match mask in status", dflt_status, 32'h0002_0003);
    chk(iflt_status === 32'h0002_0000, "R12 supervisor bit only", iflt_status, 32'h0002_0000);
    acc(32'h0000_1104, 0, 0, 3, 1, 0, 3'd4, "R2 misaligned outranks multi");
    acc(32'h0000_1400, 0, 0, 2, 0, 0, 3'd0, "R3 1K page upper bound exclusive");

    cfg(0, 2, 32'h0010_0000); cfg(1, 2, 32'h0002_0003);
    acc(32'h0010_0000, 1, 0, 2, 0, 0, 3'd2, "R6 user write without permission");
    chk(dflt_status === 32'h0001_0004, "R11 write violation status", dflt_status, 32'h0001_0004);
    acc(32'h0010_0000, 1, 0, 2, 1, 0, 3'd2, "R6 supervisor write without permission");
    acc(32'h001F_FFFC, 0, 0, 2, 0, 0, 3'd0, "R3 1M page top");
    acc(32'h0020_0000, 0, 0, 2, 0, 0, 3'd1, "R3 1M page end -> miss");

    cfg(0, 3, 32'h0040_0000); cfg(1, 3, 32'h0003_004D);
    acc(32'h007F_FFFC, 1, 0, 2, 1, 0, 3'd2, "R6 clean write-back cacheable write");
    chk(dflt_status === 32'h0003_0008, "R11 status of clean write", dflt_status, 32'h0003_0008);
    acc(32'h0040_0000, 0, 0, 2, 0, 0, 3'd2, "R7 user read without permission");
    acc(32'h0040_0000, 0, 0, 2, 1, 0, 3'd0, "R7 supervisor read always allowed");
    acc(32'h0080_0000, 0, 0, 2, 1, 0, 3'd1, "R3 4M page end -> miss");
    cfg(1, 3, 32'h0003_005D);
    acc(32'h0040_0010, 1, 0, 2, 1, 0, 3'd0, "R6 dirty page write allowed");

    cfg(0, 4, 32'h0200_0000); cfg(1, 4, 32'h0000_0006);
    acc(32'h0200_0000, 0, 0, 2, 0, 0, 3'd1, "R3 invalid entry ignored");

    acc(32'hFFC0_0010, 0, 0, 2, 1, 0, 3'd0, "R9 supervisor MMR data ok");
    acc(32'hFFC0_0010, 0, 0, 2, 0, 0, 3'd2, "R9 user MMR data violation");
    chk(dflt_addr === 32'hFFC0_0010 && dflt_status === 32'h0, "R11 violation address", dflt_addr, 32'hFFC0_0010);
    acc(32'hFFC0_0010, 1, 0, 2, 1, 1, 3'd2, "R9 second generator MMR violation");
    acc(32'hFFC0_0000, 0, 1, 2, 1, 0, 3'd1, "R9 MMR fetch miss");
    chk(iflt_status === 32'h000A_0000 && iflt_addr === 32'hFFC0_0000, "R11 inst side status", iflt_status, 32'h000A_0000);

    acc(32'hFFA0_0000, 0, 1, 2, 1, 0, 3'd0, "R10 fetch in L1 instruction window");
    acc(32'hFF80_0000, 0, 1, 2, 1, 0, 3'd2, "R10 fetch outside L1 instruction window");
    keep_d = dflt_addr; keep_i = iflt_addr;
    acc(32'hFFA0_0100, 0, 0, 2, 1, 0, 3'd5, "R10 data in instruction window");
    chk(dflt_addr === keep_d && iflt_addr === keep_i, "R10 external error leaves faults", dflt_addr, keep_d);
    acc(32'hFF80_0000, 0, 0, 2, 0, 0, 3'd0, "R10 data in L1 data region");

    cfg(2, 0, 32'h0);
    acc(32'h0000_2000, 0, 0, 2, 0, 0, 3'd0, "R8 disabled unmapped ok");
    acc(32'h0010_0000, 1, 0, 2, 0, 0, 3'd0, "R8 disabled ignores descriptors");
    acc(32'h0000_1100, 0, 0, 2, 0, 0, 3'd0, "R8 disabled no multi");
    acc(32'hFFC0_0020, 0, 0, 2, 0, 0, 3'd2, "R8 disabled still applies MMR rule");
    cfg(2, 0, 32'h1);
    acc(32'h9000_0000, 0, 1, 2, 1, 0, 3'd1, "R4 fetch miss reenabled");
    chk(iflt_addr === 32'h9000_0000 && iflt_status === 32'h000A_0000, "R11 fetch miss regs", iflt_addr, 32'h9000_0000);
    @(negedge clk);
    chk(res_done === 0, "R13 done drops", 32'(res_done), 0);

    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL R13 watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule